// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Fast-Interrupt Bank

This block gathers up to 32 level-sensitive interrupt lines into one normal interrupt request and one fast interrupt request for a processor. Software controls which lines reach each request through two independent enable masks. Each mask is changed only by atomic write-one-to-set and write-one-to-clear accesses, so no read-modify-write sequence is needed. A software-injection register is OR-ed with the external lines, which lets firmware raise any valid source by itself. Since the lines are levels, a handler acknowledges a source by masking it or by removing its cause.

External lines pass through a two-flop synchronizer. Both request outputs are registered. A parameter mask states which of the 32 inputs exist. The remaining inputs are tied off everywhere, so they read as zero and never raise a request. A second parameter builds the block as a secondary controller. In that build, a write-only pass-through register at the fast-bank status offset selects synchronized sources that are sent straight to an upstream controller, whatever the normal enable mask holds.

The register port is a simple single-cycle port. A write is taken on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`.

Top module: `lvl_intc`

## Requirements
- R1: After reset, both enable masks, the soft register and the pass-through mask are zero. `irq_o`, `fiq_o` and `bypass_o` are low, and every readable offset returns zero while no source is high.
- R2: A write to byte offset 0x08 sets the normal enable bits where the written data is 1. A write to 0x0C clears the normal enable bits where the written data is 1. No other bit changes. A read of 0x08 returns the normal enable mask.
- R3: Raw status, read at 0x04, equals the OR of the synchronized source lines and the soft bits. A change on a source line appears in raw status two clock edges after it is driven, and not after one.
- R4: Normal status, read at 0x00, equals raw status AND the normal enable mask. `irq_o` is high one edge after normal status becomes nonzero and is low one edge after it becomes zero.
- R5: A write to 0x10 sets soft bits with write-one semantics, and a write to 0x14 clears them the same way. A read of 0x10 returns the soft register.
- R6: The fast bank works as follows. Fast status is read at 0x20 and equals raw AND the fast mask. Fast raw status is read at 0x24. A write to 0x28 sets fast-mask bits and a read of 0x28 returns the mask. A write to 0x2C clears fast-mask bits. `fiq_o` follows fast status one edge later, and the two masks do not affect each other.
- R7: A source whose bit is 0 in `VALID_MASK` reads as zero in every register and never raises `irq_o`, `fiq_o` or `bypass_o`, even when it is driven, enabled or soft-set.
- R8: In the secondary build, a write to 0x20 replaces the pass-through mask with the written value. `bypass_o` equals the synchronized sources AND that mask, independent of the normal enable mask. The value 0xFFD00000 passes sources 20 and 22 to 31.
- R9: Writes to the status offsets 0x00, 0x04 and 0x24 change no state. Offsets outside the map read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Asynchronous level interrupt lines, one per source |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |
| bypass_o | output | 32 | Pass-through sources for the upstream controller (zero in the primary build) |

## Verification
The bench builds the secondary variant with `VALID_MASK` = 0xFFFFF7FE. In this build, sources 0 and 11 are absent and the pass-through register exists, so the valid-mask tie-off and the pass-through path can both be observed from one instance. A walk of every one of the 32 source lines runs under fixed, differing normal and fast masks. After each step, raw status, both masked statuses, both requests and the pass-through outputs are compared with values computed arithmetically. Separate steps cover synchronizer latency, soft injection, the mask set/clear corners and writes to read-only offsets.

// File: rtl/lvl_intc_pkg.sv
`timescale 1ns/1ps
// Shared register offsets and write-strobe type for the interrupt controller.
package lvl_intc_pkg;

    localparam logic [7:0] OFS_IRQ_STAT  = 8'h00;
    localparam logic [7:0] OFS_RAW_STAT  = 8'h04;
    localparam logic [7:0] OFS_IRQ_SET   = 8'h08;
    localparam logic [7:0] OFS_IRQ_CLR   = 8'h0C;
    localparam logic [7:0] OFS_SOFT_SET  = 8'h10;
    localparam logic [7:0] OFS_SOFT_CLR  = 8'h14;
    localparam logic [7:0] OFS_FIQ_STAT  = 8'h20;  // also pass-through load (secondary)
    localparam logic [7:0] OFS_FIQ_RAW   = 8'h24;
    localparam logic [7:0] OFS_FIQ_SET   = 8'h28;
    localparam logic [7:0] OFS_FIQ_CLR   = 8'h2C;

    // One strobe per writable register action, decoded from the port.
    typedef struct packed {
        logic irq_set;
        logic irq_clr;
        logic soft_set;
        logic soft_clr;
        logic fiq_set;
        logic fiq_clr;
        logic byp_load;
    } wr_strobe_t;

endpackage

// File: rtl/lvl_intc_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous level lines.
// Assumes each line is a level held for several clocks; no pulse capture.
module lvl_intc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the line vector one stage further each clock.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[LAST];

    // The last stage always holds what the stage before it held one edge earlier.
    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_o == $past(stage_q[(LAST == 0) ? 0 : LAST-1]))) else $error("sync shift"); // R3
endmodule

// File: rtl/lvl_intc_maskreg.sv
`timescale 1ns/1ps
// Bit-mask register with write-one-to-set, write-one-to-clear and full load.
// Assumes at most one of set/clr/load is active in a cycle (one port address);
// clear wins over set, load wins over both. Bits outside KEEP stay zero.
module lvl_intc_maskreg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] mask_q;
    logic [W-1:0] wkeep;

    assign wkeep = wdata_i & KEEP;

    // Apply the requested update to the held mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (load_i) mask_q <= wkeep;
        else if (clr_i)  mask_q <= mask_q & ~wkeep;
        else if (set_i)  mask_q <= mask_q | wkeep;
    end

    assign q_o = mask_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && !load_i) |=> ((q_o & $past(wkeep)) == $past(wkeep))) else $error("set"); // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !load_i) |=> ((q_o & $past(wkeep)) == '0)) else $error("clr"); // R5
    AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i || clr_i) && !load_i) |=> ((q_o & ~$past(wkeep)) == ($past(q_o) & ~$past(wkeep)))) else $error("keep"); // R2
    AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(wkeep))) else $error("load"); // R8
endmodule

// File: rtl/lvl_intc_decode.sv
`timescale 1ns/1ps
// Write decoder: turns the port write strobe and address into one-hot
// register actions. Assumes byte addresses with word-aligned offsets.
module lvl_intc_decode
    import lvl_intc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter bit SECONDARY = 1'b0
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_strobe_t        stb_o
);
    // Match the address against each writable offset.
    always_comb begin
        stb_o          = '0;
        if (wr_i) begin
            stb_o.irq_set  = (addr_i == ADDR_W'(OFS_IRQ_SET));
            stb_o.irq_clr  = (addr_i == ADDR_W'(OFS_IRQ_CLR));
            stb_o.soft_set = (addr_i == ADDR_W'(OFS_SOFT_SET));
            stb_o.soft_clr = (addr_i == ADDR_W'(OFS_SOFT_CLR));
            stb_o.fiq_set  = (addr_i == ADDR_W'(OFS_FIQ_SET));
            stb_o.fiq_clr  = (addr_i == ADDR_W'(OFS_FIQ_CLR));
            stb_o.byp_load = SECONDARY && (addr_i == ADDR_W'(OFS_FIQ_STAT));
        end
    end

    AST_ONE_ACTION: assert final ($onehot0(stb_o)) else $error("multiple strobes"); // R9
endmodule

// File: rtl/lvl_intc.sv
`timescale 1ns/1ps
// Level-sensitive interrupt controller top. Combines synchronized source
// lines with soft bits, masks them into a normal and a fast request and,
// in the secondary build, passes selected sources to an upstream controller.
// Assumes a single-cycle register port with combinational read data.
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int                NSRC       = 32,
    parameter int                ADDR_W     = 8,
    parameter int                SYNC_DEPTH = 2,
    parameter logic [NSRC-1:0]   VALID_MASK = '1,
    parameter bit                SECONDARY  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   reg_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [NSRC-1:0]   bypass_o
);
    wr_strobe_t      stb;
    logic [NSRC-1:0] sync_q;
    logic [NSRC-1:0] irq_en_q, fiq_en_q, soft_q, byp_q;
    logic [NSRC-1:0] raw_stat, irq_stat, fiq_stat;
    logic            irq_q, fiq_q;

    lvl_intc_sync #(.W(NSRC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(sync_q));

    lvl_intc_decode #(.ADDR_W(ADDR_W), .SECONDARY(SECONDARY)) u_dec (
        .wr_i(reg_wr), .addr_i(reg_addr), .stb_o(stb));

    lvl_intc_maskreg #(.W(NSRC), .KEEP(VALID_MASK)) u_irq_en (
        .clk(clk), .rst_n(rst_n), .set_i(stb.irq_set), .clr_i(stb.irq_clr),
        .load_i(1'b0), .wdata_i(reg_wdata), .q_o(irq_en_q));

    lvl_intc_maskreg #(.W(NSRC), .KEEP(VALID_MASK)) u_fiq_en (
        .clk(clk), .rst_n(rst_n), .set_i(stb.fiq_set), .clr_i(stb.fiq_clr),
        .load_i(1'b0), .wdata_i(reg_wdata), .q_o(fiq_en_q));

    lvl_intc_maskreg #(.W(NSRC), .KEEP(VALID_MASK)) u_soft (
        .clk(clk), .rst_n(rst_n), .set_i(stb.soft_set), .clr_i(stb.soft_clr),
        .load_i(1'b0), .wdata_i(reg_wdata), .q_o(soft_q));

    generate
        if (SECONDARY) begin : g_byp
            lvl_intc_maskreg #(.W(NSRC), .KEEP(VALID_MASK)) u_byp (
                .clk(clk), .rst_n(rst_n), .set_i(1'b0), .clr_i(1'b0),
                .load_i(stb.byp_load), .wdata_i(reg_wdata), .q_o(byp_q));
        end else begin : g_nobyp
            assign byp_q = '0;
        end
    endgenerate

    // Status vectors: raw is lines OR soft, restricted to existing sources.
    assign raw_stat = (sync_q | soft_q) & VALID_MASK;
    assign irq_stat = raw_stat & irq_en_q;
    assign fiq_stat = raw_stat & fiq_en_q;
    assign bypass_o = sync_q & byp_q & VALID_MASK;

    // Register the two request outputs from their masked status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_stat;
            fiq_q <= |fiq_stat;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    // Select the read data for the addressed offset.
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFS_IRQ_STAT): reg_rdata = irq_stat;
            ADDR_W'(OFS_RAW_STAT): reg_rdata = raw_stat;
            ADDR_W'(OFS_IRQ_SET):  reg_rdata = irq_en_q;
            ADDR_W'(OFS_SOFT_SET): reg_rdata = soft_q;
            ADDR_W'(OFS_FIQ_STAT): reg_rdata = fiq_stat;
            ADDR_W'(OFS_FIQ_RAW):  reg_rdata = raw_stat;
            ADDR_W'(OFS_FIQ_SET):  reg_rdata = fiq_en_q;
            default:               reg_rdata = '0;
        endcase
    end

    AST_IRQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(sync_q & irq_en_q & VALID_MASK) != '0) |-> irq_o) else $error("irq"); // R4
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(irq_en_q) == '0) |-> !irq_o) else $error("irq quiet"); // R4
    AST_FIQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(sync_q & fiq_en_q & VALID_MASK) != '0) |-> fiq_o) else $error("fiq"); // R6
    AST_NO_GHOST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~VALID_MASK) == '0) else $error("invalid bit"); // R7
    AST_BYPASS_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_o & ~sync_q) == '0) else $error("bypass"); // R8
endmodule

// File: tb/lvl_intc_tb_top.sv
`timescale 1ns/1ps
module lvl_intc_tb_top;
    localparam logic [31:0] V = 32'hFFFF_F7FE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, fiq_o;
    logic [31:0] bypass_o;

    // Bench model state.
    logic [31:0] m_en = '0, m_fen = '0, m_soft = '0, m_byp = '0;
    int vec = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lvl_intc #(.NSRC(32), .ADDR_W(8), .SYNC_DEPTH(2), .VALID_MASK(V), .SECONDARY(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o),
        .bypass_o(bypass_o));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Compare every observable value with the arithmetic model.
    task automatic check_all(input string req);
        logic [31:0] r, raw;
        raw = (src | m_soft) & V;
        rd(8'h04, r); chk(req, "raw", r, raw);
        rd(8'h24, r); chk(req, "fast raw", r, raw);
        rd(8'h00, r); chk(req, "irq status", r, raw & m_en);
        rd(8'h20, r); chk(req, "fiq status", r, raw & m_fen);
        chk(req, "irq_o", {31'b0, irq_o}, {31'b0, |(raw & m_en)});
        chk(req, "fiq_o", {31'b0, fiq_o}, {31'b0, |(raw & m_fen)});
        chk(req, "bypass_o", bypass_o, src & m_byp & V);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state on all offsets and outputs
        for (int a = 0; a < 64; a += 4) begin
            rd(8'(a), r); chk("R1", "reset read", r, 32'h0);
        end
        check_all("R1");

        // R2: enable set / clear semantics and read-back
        wr(8'h08, 32'hA5A5_A5A5); m_en |= 32'hA5A5_A5A5 & V;
        rd(8'h08, r); chk("R2", "en after set", r, m_en);
        wr(8'h08, 32'h0F0F_0000); m_en |= 32'h0F0F_0000 & V;
        wr(8'h0C, 32'h00FF_00FF); m_en &= ~(32'h00FF_00FF & V);
        rd(8'h08, r); chk("R2", "en after clear", r, m_en);
        rd(8'h28, r); chk("R6", "fast mask untouched", r, 32'h0);

        // R3: two-edge synchronizer latency
        wr(8'h08, 32'hFFFF_FFFF); m_en = V;
        @(negedge clk); src = 32'h0000_0020;
        @(negedge clk); rd(8'h04, r); chk("R3", "raw after one edge", r, 32'h0);
        @(negedge clk); rd(8'h04, r); chk("R3", "raw after two edges", r, 32'h20);
        chk("R4", "irq_o not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk); chk("R4", "irq_o one edge later", {31'b0, irq_o}, 32'h1);
        src = '0; settle(); check_all("R4");

        // R4 R6 R7: walk each source line under differing masks
        wr(8'h0C, 32'hFFFF_FFFF); wr(8'h08, 32'h5555_AAAA); m_en = 32'h5555_AAAA & V;
        wr(8'h28, 32'h0F0F_0F0F); m_fen = 32'h0F0F_0F0F & V;
        rd(8'h28, r); chk("R6", "fast mask read", r, m_fen);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); src = 32'h1 << i;
            settle();
            check_all((V[i]) ? "R4" : "R7");
        end
        @(negedge clk); src = '0; settle(); check_all("R4");

        // R5: soft injection
        wr(8'h10, 32'h8000_0101); m_soft |= 32'h8000_0101 & V;
        settle(); rd(8'h10, r); chk("R5", "soft read", r, m_soft);
        check_all("R5");
        wr(8'h14, 32'h0000_0100); m_soft &= ~32'h0000_0100;
        settle(); rd(8'h10, r); chk("R5", "soft after clear", r, m_soft);
        check_all("R5");
        wr(8'h14, 32'hFFFF_FFFF); m_soft = '0;

        // R6: fast clear drops fiq_o, normal mask unaffected
        @(negedge clk); src = 32'h0000_0100; settle(); check_all("R6");
        wr(8'h2C, 32'h0000_0100); m_fen &= ~32'h0000_0100;
        settle(); check_all("R6");
        rd(8'h08, r); chk("R6", "normal mask kept", r, m_en);

        // R7: absent sources driven, enabled and soft-set stay invisible
        wr(8'h08, 32'hFFFF_FFFF); m_en = V;
        wr(8'h28, 32'hFFFF_FFFF); m_fen = V;
        wr(8'h10, ~V);
        @(negedge clk); src = ~V; settle();
        rd(8'h10, r); chk("R7", "soft absent bits", r, 32'h0);
        check_all("R7");

        // R8: pass-through load, independent of the normal mask
        wr(8'h0C, 32'hFFFF_FFFF); m_en = '0;
        wr(8'h2C, 32'hFFFF_FFFF); m_fen = '0;
        wr(8'h20, 32'hFFD0_0000); m_byp = 32'hFFD0_0000;
        @(negedge clk); src = 32'hFFFF_FFFF; settle(); check_all("R8");
        chk("R8", "bypass value", bypass_o, 32'hFFD0_0000);
        wr(8'h20, 32'h0000_0003); m_byp = 32'h0000_0003;
        settle(); check_all("R8");
        chk("R8", "bypass replaced", bypass_o, 32'h0000_0002);

        // R9: writes to status offsets are ignored, holes read zero
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h08, r); chk("R9", "normal mask after status write", r, 32'h0);
        rd(8'h28, r); chk("R9", "fast mask after status write", r, 32'h0);
        rd(8'h10, r); chk("R9", "soft after status write", r, 32'h0);
        rd(8'h18, r); chk("R9", "hole 0x18", r, 32'h0);
        rd(8'h3C, r); chk("R9", "hole 0x3C", r, 32'h0);
        check_all("R9");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule